// File: doc/BRIEF.md
# Multi-Channel Byte Stream Merger

This block collects bytes from several per-channel sample FIFOs and merges them into one byte stream. The stream goes to an external USB-to-parallel FIFO bridge, which takes one byte per write strobe while its transmit-ready flag is high. A channel's data always goes out as a burst. The burst starts with one code byte that names the channel, and the channel's FIFO bytes follow in order until the FIFO reads empty. The block then looks for the next channel with data.

The channel FIFOs are first-word-fall-through. The word at the head of a FIFO is always visible, and a one-cycle read-enable pulse removes it. The block pulses a channel's read enable only when it moves that head byte into its output register. Each byte it reads is therefore written to the bridge exactly once. Channels get service in rotating order. The search starts at the channel after the one whose burst ended last.

Top module: `cfs_stream_merge`

## Requirements
- R1: While reset is high and in the cycle after it, the write strobe is low and no read enable is high.
- R2: Every burst starts with a code byte. Its upper four bits are the marker value (default 0xA) and its lower four bits are the channel index, so channel 2 gives 0x A2. The first accepted byte after the strobe has been low is always such a code byte.
- R3: After the code byte, the burst carries that channel's FIFO bytes in the order they were pushed. No byte is lost, repeated or sent under the wrong channel.
- R4: A burst ends only when the channel's empty flag is seen high at a point where the next byte could be read. Bytes pushed into the channel while its burst is open extend that same burst, with no second code byte.
- R5: When several channels hold data, the next burst goes to the first non-empty channel after the one served last, counting upward and wrapping. After reset, channel 0 comes first.
- R6: A byte is transferred on a rising edge where the strobe and transmit-ready are both high. While the strobe is high and transmit-ready is low, the strobe and the data bus keep their values, and no read enable is pulsed.
- R7: Read enables are one-hot or zero. They are never high for an empty channel, and the number of read pulses equals the number of data bytes sent.
- R8: When every channel is empty and no burst is open, the strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_data | input | NUM_CH*8 | Head byte of each channel FIFO; channel i is bits [8i+7:8i] |
| ch_empty | input | NUM_CH | Empty flag of each channel FIFO |
| ch_rd | output | NUM_CH | Read enable to each channel FIFO, one cycle per byte taken |
| br_ready | input | 1 | Bridge transmit-ready flag |
| br_data | output | 8 | Byte toward the bridge |
| br_wr | output | 1 | Write strobe toward the bridge; byte accepted when br_ready is high too |

## Verification
Two situations are the hardest to reach from the ports. One is a burst that grows because bytes arrive after its code byte was loaded but before the FIFO was seen empty. The other is a stall that lands exactly when the output register is about to be refilled. A directed case holds transmit-ready low after the code byte appears, pushes further bytes into the same channel, and then releases the bridge. A long random phase toggles transmit-ready on about one cycle in four while random pushes land in every channel. Every stall edge is then crossed while a burst is open, and a per-channel scoreboard catches any lost or repeated byte.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_BURST = 1'b1
  } merge_state_t;

  // Channel code byte: marker in the upper nibble, channel index below.
  function automatic logic [7:0] code_byte(logic [3:0] marker, logic [3:0] idx);
    return {marker, idx};
  endfunction

endpackage

// File: rtl/cfs_rr_pick.sv
module cfs_rr_pick #(
  parameter int NUM_CH = 4,
  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] req,
  input  logic [IW-1:0]     last,
  output logic              found,
  output logic [IW-1:0]     pick
);

  // Search starts one past the last served channel and wraps.
  always_comb begin
    int          tmp;
    logic [IW-1:0] cand;
    found = 1'b0;
    pick  = last;
    for (int off = 1; off <= NUM_CH; off++) begin
      tmp  = (int'(last) + off) % NUM_CH;
      cand = tmp[IW-1:0];
      if (!found && req[cand]) begin
        found = 1'b1;
        pick  = cand;
      end
    end
  end

endmodule

// File: rtl/cfs_chan_sel.sv
module cfs_chan_sel #(
  parameter int NUM_CH = 4,
  parameter int BYTE_W = 8,
  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH*BYTE_W-1:0] data_flat,
  input  logic [NUM_CH-1:0]        empty,
  input  logic [IW-1:0]            sel,
  output logic [BYTE_W-1:0]        sel_data,
  output logic                     sel_empty
);

  logic [BYTE_W-1:0] lane [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    assign lane[g] = data_flat[g*BYTE_W +: BYTE_W];
  end

  assign sel_data  = lane[sel];
  assign sel_empty = empty[sel];

endmodule

// File: rtl/cfs_stream_merge.sv
module cfs_stream_merge
  import cfs_pkg::*;
#(
  parameter int         NUM_CH = 4,
  parameter logic [3:0] MARK   = 4'hA,
  localparam int BYTE_W = 8,
  localparam int IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH*BYTE_W-1:0] ch_data,
  input  logic [NUM_CH-1:0]        ch_empty,
  output logic [NUM_CH-1:0]        ch_rd,
  input  logic                     br_ready,
  output logic [BYTE_W-1:0]        br_data,
  output logic                     br_wr
);

  merge_state_t      state;
  logic [IW-1:0]     cur_ch;
  logic [IW-1:0]     last_ch;
  logic              out_vld;
  logic [BYTE_W-1:0] out_byte;

  logic              pick_found;
  logic [IW-1:0]     pick_ch;
  logic [BYTE_W-1:0] head_byte;
  logic              head_empty;
  logic              slot_free;

  cfs_rr_pick #(.NUM_CH(NUM_CH)) u_pick (
    .req   (~ch_empty),
    .last  (last_ch),
    .found (pick_found),
    .pick  (pick_ch)
  );

  cfs_chan_sel #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_sel (
    .data_flat (ch_data),
    .empty     (ch_empty),
    .sel       (cur_ch),
    .sel_data  (head_byte),
    .sel_empty (head_empty)
  );

  // Output register may be reloaded when empty or being accepted now.
  assign slot_free = !out_vld || br_ready;

  always_comb begin
    ch_rd = '0;
    if (state == ST_BURST && slot_free && !head_empty)
      ch_rd[cur_ch] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur_ch   <= '0;
      last_ch  <= IW'(NUM_CH - 1);
      out_vld  <= 1'b0;
      out_byte <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (pick_found) begin
            out_byte <= code_byte(MARK, 4'(pick_ch));
            out_vld  <= 1'b1;
            cur_ch   <= pick_ch;
            state    <= ST_BURST;
          end
        end
        ST_BURST: begin
          if (slot_free) begin
            if (!head_empty) begin
              out_byte <= head_byte;
              out_vld  <= 1'b1;
            end else begin
              out_vld  <= 1'b0;
              last_ch  <= cur_ch;
              state    <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign br_data = out_byte;
  assign br_wr   = out_vld;

endmodule

// File: rtl/cfs_stream_merge_chk.sv
module cfs_stream_merge_chk #(
  parameter int         NUM_CH = 4,
  parameter logic [3:0] MARK   = 4'hA
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] ch_empty,
  input logic [NUM_CH-1:0] ch_rd,
  input logic              br_ready,
  input logic [7:0]        br_data,
  input logic              br_wr
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!br_wr && ch_rd == '0));

  assert_code_first_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(br_wr) |-> br_data[7:4] == MARK);

  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (br_wr && !br_ready) |=> (br_wr && $stable(br_data)));

  assert_no_read_on_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (ch_rd != '0) |-> (!br_wr || br_ready));

  assert_rd_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ch_rd));

  assert_rd_not_empty_R7: assert property (@(posedge clk) disable iff (rst)
    (ch_rd & ch_empty) == '0);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (&ch_empty && !br_wr) |=> !br_wr);

endmodule

bind cfs_stream_merge cfs_stream_merge_chk #(.NUM_CH(NUM_CH), .MARK(MARK)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ch_empty (ch_empty),
  .ch_rd    (ch_rd),
  .br_ready (br_ready),
  .br_data  (br_data),
  .br_wr    (br_wr)
);

// File: tb/test_cfs_stream_merge.sv
module test_cfs_stream_merge;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 4;
  localparam int DEPTH      = 512;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NUM_CH*8-1:0] ch_data;
  logic [NUM_CH-1:0]   ch_empty;
  logic [NUM_CH-1:0]   ch_rd;
  logic                br_ready = 1'b0;
  logic [7:0]          br_data;
  logic                br_wr;

  cfs_stream_merge #(.NUM_CH(NUM_CH)) i_cfs_stream_merge (
    .clk(clk), .rst(rst), .ch_data(ch_data), .ch_empty(ch_empty),
    .ch_rd(ch_rd), .br_ready(br_ready), .br_data(br_data), .br_wr(br_wr)
  );

  // FWFT FIFO model per channel
  logic [7:0]  mem [NUM_CH][DEPTH];
  int unsigned wp [NUM_CH];
  int unsigned rp [NUM_CH];
  int unsigned ep [NUM_CH];

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      ch_empty[c]      = (wp[c] == rp[c]);
      ch_data[c*8 +: 8] = mem[c][rp[c] % DEPTH];
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NUM_CH; c++)
      if (rst) rp[c] <= 0;
      else if (ch_rd[c]) rp[c] <= rp[c] + 1;
  end

  int nchk = 0, nfail = 0;
  int pops = 0, nbytes = 0, nh = 0, wr_idle = 0;
  logic [7:0] hdr_log [256];
  bit in_burst = 0;
  int cur_ch = 0;

  task automatic check(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(int c, logic [7:0] b);
    if (wp[c] < DEPTH) begin
      mem[c][wp[c] % DEPTH] = b;
      wp[c] = wp[c] + 1;
    end
  endtask

  // Scoreboard sampled at the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (ch_rd != '0) pops++;
      if (br_wr) wr_idle++;
      if (br_wr && br_ready) begin
        if (!in_burst) begin
          check(br_data[7:4] == 4'hA && int'(br_data[3:0]) < NUM_CH,
                "R2 code byte", br_data, 8'hA0);
          cur_ch = int'(br_data[3:0]) % NUM_CH;
          in_burst = 1;
          if (nh < 256) hdr_log[nh] = br_data;
          nh++;
        end else begin
          check(ep[cur_ch] < wp[cur_ch] && br_data == mem[cur_ch][ep[cur_ch] % DEPTH],
                "R3 data order", br_data, mem[cur_ch][ep[cur_ch] % DEPTH]);
          ep[cur_ch]++;
          nbytes++;
        end
      end else if (!br_wr) begin
        in_burst = 0;
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drain();
    br_ready = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (&ch_empty && !br_wr) break;
    end
    step(2);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int base;
    for (int c = 0; c < NUM_CH; c++) begin
      wp[c] = 0; ep[c] = 0;
    end
    step(3);
    rst = 1'b0;
    @(negedge clk);
    check(!br_wr && ch_rd == '0, "R1 reset state", {br_wr, ch_rd}, 0);
    step(1);

    // R5 order after reset and R6 hold while stalled
    for (int c = 0; c < NUM_CH; c++) begin
      push(c, 8'(8'h10 * c + 1));
      push(c, 8'(8'h10 * c + 2));
    end
    step(2);
    @(negedge clk);
    check(br_wr && br_data == 8'hA0, "R6 stalled code byte", br_data, 8'hA0);
    step(3);
    @(negedge clk);
    check(br_wr && br_data == 8'hA0 && pops == 0, "R6 hold over stall", br_data, 8'hA0);
    drain();
    for (int i = 0; i < NUM_CH; i++)
      check(hdr_log[i] == 8'(8'hA0 + i), "R5 order from reset", hdr_log[i], 8'hA0 + i);

    // R5 wrap: last served was channel 3, so channel 1 precedes channel 2
    base = nh;
    step(1);
    push(2, 8'h5C);
    push(1, 8'h3B);
    drain();
    check(nh == base + 2, "R5 burst count", nh - base, 2);
    check(hdr_log[base] == 8'hA1, "R5 first after wrap", hdr_log[base], 8'hA1);
    check(hdr_log[base + 1] == 8'hA2, "R5 second after wrap", hdr_log[base + 1], 8'hA2);

    // R4 burst extended by late arrivals
    br_ready = 1'b0;
    base = nh;
    push(3, 8'hC1);
    step(3);
    push(3, 8'hC2);
    push(3, 8'hC3);
    step(1);
    drain();
    check(nh == base + 1, "R4 single code byte", nh - base, 1);
    check(hdr_log[base] == 8'hA3, "R4 code for channel 3", hdr_log[base], 8'hA3);
    check(ep[3] == wp[3], "R4 all bytes in burst", ep[3], wp[3]);

    // R8 no writes while all empty
    wr_idle = 0;
    step(20);
    check(wr_idle == 0, "R8 idle strobe", wr_idle, 0);

    // Random phase
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      br_ready = ($urandom % 4) != 0;
      if (($urandom % 3) == 0) push(int'($urandom % NUM_CH), 8'($urandom));
      step(1);
    end
    drain();
    for (int c = 0; c < NUM_CH; c++)
      check(ep[c] == wp[c], "R3 no loss per channel", ep[c], wp[c]);
    check(pops == nbytes, "R7 read pulses per byte", pops, nbytes);
    check(!br_wr && &ch_empty, "R8 quiet after drain", br_wr, 0);

    finish_run();
  end

endmodule